// File: doc/BRIEF.md
# Per-Subaddress Ping-Pong Buffer Manager

This block sits between the message engine of a serial-bus remote terminal and its host. It holds two 16-bit buffer pointers for each of 32 subaddresses. One is the primary pointer, which the terminal uses for every receive or transmit message. The other is the secondary pointer, which the host owns while the terminal works on the primary. Software loads both pointers and selects, subaddress by subaddress, whether the pair takes part in double buffering.

When a periodic interval ends, a one-cycle strobe exchanges primary and secondary on every subaddress that has ping-pong enabled. A message that is still running on a subaddress delays the exchange on that subaddress until the message closes. For bulk transfers the block also counts received messages on each subaddress. It pulses an interrupt that carries the subaddress number when a programmed count is reached, then starts counting again.

Top module: `pingpong_buf_mgr`

## Requirements
- R1: After reset every pointer reads 0, no subaddress has ping-pong enabled, every message limit is 0 (meaning 256), every counter is zero and `irq_valid` is low.
- R2: `term_ptr` shows the primary pointer of `term_sa` and `host_rd_ptr` shows the secondary pointer of `host_sa`, both without a clock delay. A clock edge with `host_wr_pri` or `host_wr_sec` high stores `host_wdata` into the primary or the secondary pointer of `host_sa`.
- R3: A clock edge with `interval_end` high exchanges the primary and secondary pointers of every enabled subaddress that has no open message. The new values are visible after that edge.
- R4: A subaddress whose enable is 0 never exchanges its pointers. A clock edge with `host_en_wr` high sets the enable of `host_sa` to `host_en_val`.
- R5: `term_start` while no message is open opens a message on `term_sa`, and `term_start` while a message is open has no effect. `term_done` closes the open message. An interval end that hits the subaddress of an open message is carried out at the closing edge. Several interval ends during one message give a single exchange. If `term_done` and `interval_end` fall on the same edge, the pointers are exchanged once, at that edge.
- R6: When a host pointer write and an exchange hit the same subaddress on the same edge, the exchange happens first. The written value then lands in the pointer named by the write (primary or secondary) after the exchange.
- R7: An edge with `term_done` high and `term_rx` high counts one received message on the subaddress of the open message. With `term_rx` low the message is not counted.
- R8: When a subaddress's count reaches its limit, `irq_valid` is high for exactly the one cycle after that edge, with `irq_sa` giving the subaddress. The counter then restarts from zero.
- R9: An edge with `host_cnt_wr` high loads `host_cnt_val` as the limit of `host_sa` and clears its counter. A limit of 0 means 256 messages.
- R10: Disabling a subaddress cancels any exchange it still has pending from an open message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| term_start | input | 1 | Terminal opens a message on `term_sa` |
| term_done | input | 1 | Terminal closes the open message |
| term_rx | input | 1 | With `term_done`: the closing message was a receive |
| term_sa | input | 5 | Subaddress for message open and primary read |
| term_ptr | output | 16 | Primary pointer of `term_sa` |
| host_sa | input | 5 | Subaddress addressed by the host |
| host_wdata | input | 16 | Pointer value to write |
| host_wr_pri | input | 1 | Write primary pointer of `host_sa` |
| host_wr_sec | input | 1 | Write secondary pointer of `host_sa` |
| host_en_wr | input | 1 | Write ping-pong enable of `host_sa` |
| host_en_val | input | 1 | Enable value to write |
| host_cnt_wr | input | 1 | Load message limit of `host_sa` |
| host_cnt_val | input | 8 | Message limit (0 means 256) |
| host_rd_ptr | output | 16 | Secondary pointer of `host_sa` |
| interval_end | input | 1 | One-cycle end-of-interval strobe |
| irq_valid | output | 1 | One-cycle message-count interrupt |
| irq_sa | output | 5 | Subaddress whose limit was reached |

## Verification
Two pairs of events can land on the same edge. In the first, the interval strobe coincides with a host write to the pointer pair being exchanged. The bench drives `interval_end` together with `host_wr_pri` and then together with `host_wr_sec` on an enabled subaddress, and it requires the written word to appear in the named pointer while the other pointer holds the value that was exchanged into it. In the second, the strobe falls on the very edge where a message on that subaddress closes. The bench raises `term_done` and `interval_end` together and requires exactly one exchange at that edge. Interrupts are judged by a scoreboard of expected subaddresses against the pulses that appear.

// File: rtl/pp_pkg.sv
// Package: shared types of the ping-pong buffer manager.
// Assumes: nothing; holds only type definitions.
package pp_pkg;
    // Whether a terminal message is currently open.
    typedef enum logic {
        MSG_IDLE = 1'b0,
        MSG_BUSY = 1'b1
    } msg_state_e;
endpackage

// File: rtl/pp_msg_tracker.sv
// Module: tracks the one terminal message that may be open at a time.
// Assumes: the terminal opens with term_start and closes with term_done;
// a start while busy is ignored, and a done while idle is ignored.
module pp_msg_tracker #(
    parameter int SA_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            term_start,
    input  logic            term_done,
    input  logic [SA_W-1:0] term_sa,
    output logic            busy,
    output logic [SA_W-1:0] act_sa,
    output logic            close
);
    import pp_pkg::*;

    msg_state_e state_q;

    // Open and close the message and latch its subaddress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MSG_IDLE;
            act_sa  <= '0;
        end else begin
            case (state_q)
                MSG_IDLE: begin
                    if (term_start) begin
                        state_q <= MSG_BUSY;
                        act_sa  <= term_sa;
                    end
                end
                MSG_BUSY: begin
                    if (term_done) state_q <= MSG_IDLE;
                end
                default: state_q <= MSG_IDLE;
            endcase
        end
    end

    assign busy  = (state_q == MSG_BUSY);
    assign close = busy && term_done;
endmodule

// File: rtl/pp_ptr_bank.sv
// Module: two pointer slots, a select bit, an enable and a pending-swap flag
// per subaddress. An exchange flips the select bit; host writes land in the
// slot named after any same-edge exchange.
// Assumes: only one message is open at a time (busy/act_sa/close from tracker).
module pp_ptr_bank #(
    parameter int NUM_SA = 32,
    parameter int SA_W   = 5,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              interval_end,
    input  logic              busy,
    input  logic [SA_W-1:0]   act_sa,
    input  logic              close,
    input  logic [SA_W-1:0]   term_sa,
    input  logic [SA_W-1:0]   host_sa,
    input  logic [PTR_W-1:0]  host_wdata,
    input  logic              host_wr_pri,
    input  logic              host_wr_sec,
    input  logic              host_en_wr,
    input  logic              host_en_val,
    output logic [PTR_W-1:0]  term_ptr,
    output logic [PTR_W-1:0]  host_rd_ptr,
    output logic [NUM_SA-1:0] swap_fire,
    output logic [NUM_SA-1:0] pend,
    output logic [NUM_SA-1:0] en_q
);
    logic [PTR_W-1:0] pri_vec [NUM_SA];
    logic [PTR_W-1:0] sec_vec [NUM_SA];

    for (genvar i = 0; i < NUM_SA; i++) begin : g_sa
        logic [PTR_W-1:0] slot_a;
        logic [PTR_W-1:0] slot_b;
        logic             sel;
        logic             sel_nxt;
        logic             on_act;
        logic             hold;
        logic             host_hit;

        assign on_act   = busy && (act_sa == SA_W'(i));
        assign hold     = on_act && !close;
        assign host_hit = (host_sa == SA_W'(i));
        assign swap_fire[i] = en_q[i] &&
                              ((interval_end && !hold) || (pend[i] && on_act && close));
        assign sel_nxt  = swap_fire[i] ? ~sel : sel;

        // Flip the primary/secondary selection on an exchange.
        always_ff @(posedge clk) begin
            if (!rst_n) sel <= 1'b0;
            else        sel <= sel_nxt;
        end

        // Store host pointer writes into the slot they name after the exchange.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_a <= '0;
                slot_b <= '0;
            end else if (host_hit) begin
                if ((host_wr_pri && sel_nxt) || (host_wr_sec && !sel_nxt)) slot_b <= host_wdata;
                if ((host_wr_pri && !sel_nxt) || (host_wr_sec && sel_nxt)) slot_a <= host_wdata;
            end
        end

        // Hold the per-subaddress ping-pong enable.
        always_ff @(posedge clk) begin
            if (!rst_n)                     en_q[i] <= 1'b0;
            else if (host_en_wr && host_hit) en_q[i] <= host_en_val;
        end

        // Remember an exchange deferred by an open message; drop it when disabled.
        always_ff @(posedge clk) begin
            if (!rst_n)                      pend[i] <= 1'b0;
            else if (!en_q[i])               pend[i] <= 1'b0;
            else if (swap_fire[i])           pend[i] <= 1'b0;
            else if (interval_end && hold)   pend[i] <= 1'b1;
        end

        assign pri_vec[i] = sel ? slot_b : slot_a;
        assign sec_vec[i] = sel ? slot_a : slot_b;
    end

    assign term_ptr    = pri_vec[term_sa];
    assign host_rd_ptr = sec_vec[host_sa];
endmodule

// File: rtl/pp_rx_counter.sv
// Module: per-subaddress received-message counters with programmable limits.
// A limit of 0 means 2**CNT_W. Reaching the limit registers a one-cycle
// interrupt with the subaddress and restarts the counter.
// Assumes: at most one message closes per cycle.
module pp_rx_counter #(
    parameter int NUM_SA = 32,
    parameter int SA_W   = 5,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close,
    input  logic             term_rx,
    input  logic [SA_W-1:0]  act_sa,
    input  logic [SA_W-1:0]  host_sa,
    input  logic             host_cnt_wr,
    input  logic [CNT_W-1:0] host_cnt_val,
    output logic             irq_valid,
    output logic [SA_W-1:0]  irq_sa
);
    logic [NUM_SA-1:0] hit_vec;

    for (genvar i = 0; i < NUM_SA; i++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] lim_q;
        logic [CNT_W-1:0] cnt_inc;
        logic             load;
        logic             count;

        assign load    = host_cnt_wr && (host_sa == SA_W'(i));
        assign count   = close && term_rx && (act_sa == SA_W'(i)) && !load;
        assign cnt_inc = cnt_q + CNT_W'(1);
        assign hit_vec[i] = count && (cnt_inc == lim_q);

        // Load the limit, or count a received message and restart on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                lim_q <= '0;
            end else if (load) begin
                lim_q <= host_cnt_val;
                cnt_q <= '0;
            end else if (count) begin
                cnt_q <= hit_vec[i] ? '0 : cnt_inc;
            end
        end
    end

    // Register the interrupt pulse and its subaddress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_sa    <= '0;
        end else begin
            irq_valid <= |hit_vec;
            if (|hit_vec) irq_sa <= act_sa;
        end
    end
endmodule

// File: rtl/pingpong_buf_mgr.sv
// Module: top of the per-subaddress ping-pong buffer manager. Joins the
// message tracker, the pointer bank and the received-message counters.
// Assumes: synchronous active-low reset; interval_end is a one-cycle strobe.
module pingpong_buf_mgr #(
    parameter int NUM_SA = 32,
    parameter int PTR_W  = 16,
    parameter int CNT_W  = 8,
    localparam int SA_W  = $clog2(NUM_SA)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             term_start,
    input  logic             term_done,
    input  logic             term_rx,
    input  logic [SA_W-1:0]  term_sa,
    output logic [PTR_W-1:0] term_ptr,
    input  logic [SA_W-1:0]  host_sa,
    input  logic [PTR_W-1:0] host_wdata,
    input  logic             host_wr_pri,
    input  logic             host_wr_sec,
    input  logic             host_en_wr,
    input  logic             host_en_val,
    input  logic             host_cnt_wr,
    input  logic [CNT_W-1:0] host_cnt_val,
    output logic [PTR_W-1:0] host_rd_ptr,
    input  logic             interval_end,
    output logic             irq_valid,
    output logic [SA_W-1:0]  irq_sa
);
    logic              busy;
    logic              close;
    logic [SA_W-1:0]   act_sa;
    logic [NUM_SA-1:0] swap_fire;
    logic [NUM_SA-1:0] pend;
    logic [NUM_SA-1:0] en_q;

    pp_msg_tracker #(.SA_W(SA_W)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .term_start(term_start), .term_done(term_done), .term_sa(term_sa),
        .busy(busy), .act_sa(act_sa), .close(close)
    );

    pp_ptr_bank #(.NUM_SA(NUM_SA), .SA_W(SA_W), .PTR_W(PTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .interval_end(interval_end), .busy(busy), .act_sa(act_sa), .close(close),
        .term_sa(term_sa), .host_sa(host_sa), .host_wdata(host_wdata),
        .host_wr_pri(host_wr_pri), .host_wr_sec(host_wr_sec),
        .host_en_wr(host_en_wr), .host_en_val(host_en_val),
        .term_ptr(term_ptr), .host_rd_ptr(host_rd_ptr),
        .swap_fire(swap_fire), .pend(pend), .en_q(en_q)
    );

    pp_rx_counter #(.NUM_SA(NUM_SA), .SA_W(SA_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .close(close), .term_rx(term_rx), .act_sa(act_sa),
        .host_sa(host_sa), .host_cnt_wr(host_cnt_wr), .host_cnt_val(host_cnt_val),
        .irq_valid(irq_valid), .irq_sa(irq_sa)
    );
endmodule

// File: rtl/pingpong_buf_mgr_sva.sv
// Module: assertion checker bound to pingpong_buf_mgr; observes the tracker,
// bank and counter outputs and the top-level ports.
module pingpong_buf_mgr_sva #(
    parameter int NUM_SA = 32,
    parameter int SA_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              interval_end,
    input logic              term_done,
    input logic              term_rx,
    input logic              irq_valid,
    input logic              busy,
    input logic              close,
    input logic [SA_W-1:0]   act_sa,
    input logic [NUM_SA-1:0] swap_fire,
    input logic [NUM_SA-1:0] pend,
    input logic [NUM_SA-1:0] en_q
);
    // R5: an open message blocks the exchange of its own subaddress.
    a_r5_hold_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !term_done) |-> !swap_fire[act_sa]);

    // R5: a deferred exchange is carried out when the message closes.
    a_r5_release_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        (close && pend[act_sa] && en_q[act_sa]) |-> swap_fire[act_sa]);

    // R4 and R10: no exchange on a disabled subaddress.
    a_r4_no_swap_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_fire & ~en_q) == '0);

    // R3: exchanges only on an interval end or a message close.
    a_r3_swap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|swap_fire) |-> (interval_end || close));

    // R7: an interrupt follows a closing receive message.
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(close && term_rx));

    // R8: the interrupt lasts a single cycle.
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);
endmodule

bind pingpong_buf_mgr pingpong_buf_mgr_sva #(.NUM_SA(NUM_SA), .SA_W(SA_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .interval_end(interval_end),
    .term_done(term_done), .term_rx(term_rx), .irq_valid(irq_valid),
    .busy(busy), .close(close), .act_sa(act_sa),
    .swap_fire(swap_fire), .pend(pend), .en_q(en_q)
);

// File: tb/pingpong_buf_mgr_test.sv
module pingpong_buf_mgr_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        term_start = 0, term_done = 0, term_rx = 0;
    logic [4:0]  term_sa = '0;
    logic [15:0] term_ptr;
    logic [4:0]  host_sa = '0;
    logic [15:0] host_wdata = '0;
    logic        host_wr_pri = 0, host_wr_sec = 0, host_en_wr = 0, host_en_val = 0;
    logic        host_cnt_wr = 0;
    logic [7:0]  host_cnt_val = '0;
    logic [15:0] host_rd_ptr;
    logic        interval_end = 0;
    logic        irq_valid;
    logic [4:0]  irq_sa;

    int n_chk = 0;
    int n_fail = 0;
    int exp_cnt [32];
    int exp_lim [32];
    logic [4:0] irq_q [$];

    pingpong_buf_mgr uut (
        .clk(clk), .rst_n(rst_n),
        .term_start(term_start), .term_done(term_done), .term_rx(term_rx),
        .term_sa(term_sa), .term_ptr(term_ptr),
        .host_sa(host_sa), .host_wdata(host_wdata),
        .host_wr_pri(host_wr_pri), .host_wr_sec(host_wr_sec),
        .host_en_wr(host_en_wr), .host_en_val(host_en_val),
        .host_cnt_wr(host_cnt_wr), .host_cnt_val(host_cnt_val),
        .host_rd_ptr(host_rd_ptr), .interval_end(interval_end),
        .irq_valid(irq_valid), .irq_sa(irq_sa)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ptrs(string req, logic [4:0] sa, logic [15:0] p, logic [15:0] s);
        term_sa = sa; host_sa = sa; #1;
        check({req, " primary"}, term_ptr, p);
        check({req, " secondary"}, host_rd_ptr, s);
    endtask

    task automatic wr_ptr(logic [4:0] sa, logic pri, logic [15:0] v);
        host_sa = sa; host_wdata = v; host_wr_pri = pri; host_wr_sec = !pri;
        tick();
        host_wr_pri = 0; host_wr_sec = 0;
    endtask

    task automatic set_en(logic [4:0] sa, logic v);
        host_sa = sa; host_en_val = v; host_en_wr = 1;
        tick();
        host_en_wr = 0;
    endtask

    task automatic set_lim(logic [4:0] sa, logic [7:0] v);
        host_sa = sa; host_cnt_val = v; host_cnt_wr = 1;
        exp_lim[sa] = v; exp_cnt[sa] = 0;
        tick();
        host_cnt_wr = 0;
    endtask

    task automatic pulse_interval();
        interval_end = 1;
        tick();
        interval_end = 0;
    endtask

    task automatic open_msg(logic [4:0] sa);
        term_sa = sa; term_start = 1;
        tick();
        term_start = 0;
    endtask

    // Close the open message; the driver side of the scoreboard (R7, R8, R9).
    task automatic close_msg(logic [4:0] sa, logic rx, logic with_interval);
        int eff;
        term_done = 1; term_rx = rx; interval_end = with_interval;
        if (rx) begin
            eff = (exp_lim[sa] == 0) ? 256 : exp_lim[sa];
            exp_cnt[sa]++;
            if (exp_cnt[sa] == eff) begin
                irq_q.push_back(sa);
                exp_cnt[sa] = 0;
            end
        end
        tick();
        term_done = 0; term_rx = 0; interval_end = 0;
    endtask

    task automatic msg(logic [4:0] sa, logic rx);
        open_msg(sa);
        close_msg(sa, rx, 1'b0);
    endtask

    task automatic expect_drained(string req);
        tick();
        n_chk++;
        if (irq_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s pending interrupts actual=%0d expected=0", req, irq_q.size());
            irq_q.delete();
        end
    endtask

    // Monitor side of the scoreboard: every pulse must match the next expected one.
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            n_chk++;
            if (irq_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8 unexpected interrupt actual=%0d expected=none", irq_sa);
            end else begin
                logic [4:0] e;
                e = irq_q.pop_front();
                if (irq_sa !== e) begin
                    n_fail++;
                    $display("FAIL R8 interrupt subaddress actual=%0d expected=%0d", irq_sa, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin exp_cnt[i] = 0; exp_lim[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        check_ptrs("R1", 5'd5, 16'h0000, 16'h0000);
        check("R1 irq", {15'd0, irq_valid}, 16'd0);

        // R2: pointer loads
        wr_ptr(5'd2, 1, 16'h1111); wr_ptr(5'd2, 0, 16'h2222);
        wr_ptr(5'd7, 1, 16'h7a7a); wr_ptr(5'd7, 0, 16'h7b7b);
        check_ptrs("R2 sa2", 5'd2, 16'h1111, 16'h2222);
        check_ptrs("R2 sa7", 5'd7, 16'h7a7a, 16'h7b7b);

        // R3 / R4: only the enabled subaddress swaps
        set_en(5'd2, 1);
        pulse_interval();
        check_ptrs("R3 swap", 5'd2, 16'h2222, 16'h1111);
        check_ptrs("R4 disabled", 5'd7, 16'h7a7a, 16'h7b7b);

        // R5: deferral while open, single swap for two interval ends
        set_en(5'd7, 1);
        open_msg(5'd7);
        pulse_interval();
        check_ptrs("R5 held", 5'd7, 16'h7a7a, 16'h7b7b);
        check_ptrs("R3 other sa", 5'd2, 16'h1111, 16'h2222);
        pulse_interval();
        check_ptrs("R5 still held", 5'd7, 16'h7a7a, 16'h7b7b);
        term_start = 1; term_sa = 5'd9; tick(); term_start = 0;  // R5: ignored while open
        close_msg(5'd7, 1'b0, 1'b0);
        check_ptrs("R5 released once", 5'd7, 16'h7b7b, 16'h7a7a);
        check_ptrs("R5 start ignored", 5'd2, 16'h2222, 16'h1111);

        // R5: close and interval end on the same edge
        open_msg(5'd7);
        close_msg(5'd7, 1'b0, 1'b1);
        check_ptrs("R5 coincident close", 5'd7, 16'h7a7a, 16'h7b7b);
        check_ptrs("R5 coincident other", 5'd2, 16'h1111, 16'h2222);

        // R6: host write on the exchange edge
        host_sa = 5'd2; host_wdata = 16'hC0DE; host_wr_pri = 1; interval_end = 1;
        tick(); host_wr_pri = 0; interval_end = 0;
        check_ptrs("R6 primary write", 5'd2, 16'hC0DE, 16'h1111);
        host_sa = 5'd2; host_wdata = 16'hBEEF; host_wr_sec = 1; interval_end = 1;
        tick(); host_wr_sec = 0; interval_end = 0;
        check_ptrs("R6 secondary write", 5'd2, 16'h1111, 16'hBEEF);

        // R10: disabling cancels a pending exchange
        open_msg(5'd7);
        pulse_interval();
        set_en(5'd7, 0);
        close_msg(5'd7, 1'b0, 1'b0);
        check_ptrs("R10 cancelled", 5'd7, 16'h7a7a, 16'h7b7b);
        pulse_interval();
        check_ptrs("R10 stays", 5'd7, 16'h7a7a, 16'h7b7b);

        // R7 / R8: limit 3, transmit messages not counted
        set_lim(5'd9, 8'd3);
        msg(5'd9, 1); msg(5'd9, 1); msg(5'd9, 0); msg(5'd9, 0);
        expect_drained("R7 no irq yet");
        msg(5'd9, 1);
        expect_drained("R8 irq at limit");
        msg(5'd9, 1); msg(5'd9, 1); msg(5'd9, 1);
        expect_drained("R8 reload");

        // R9: reload clears the counter
        msg(5'd9, 1); msg(5'd9, 1);
        set_lim(5'd9, 8'd3);
        msg(5'd9, 1); msg(5'd9, 1);
        expect_drained("R9 cleared count");
        msg(5'd9, 1);
        expect_drained("R9 irq after reload");

        // R9: limit 0 means 256
        for (int k = 0; k < 255; k++) msg(5'd4, 1);
        expect_drained("R9 none at 255");
        msg(5'd4, 1);
        expect_drained("R9 irq at 256");

        tick();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule